// File: doc/BRIEF.md
# LPC DMA SYNC-Driven Request Termination

This block sits on the host side of a low pin count bus and follows a DMA cycle one byte at a time. For each data byte, the peripheral returns a status nibble (SYNC), and the bus front end hands it over already decoded, together with a byte strobe. From this nibble the block decides three things:

- whether the internal DMA request to the legacy DMA controller stays asserted;
- whether a two-byte grant is cut short after its first byte;
- whether the peripheral broke protocol.

It also issues a completion pulse, which the DMA controller uses to step its address and count.

A new grant opens with a start pulse. At that point the block latches three attributes: the granted size (one or two bytes), the direction, and whether the channel is 16 bits wide. The byte strobe marks the data byte that a SYNC nibble qualifies. On a read that nibble follows the byte; on a write it precedes the byte. In both cases, a terminating nibble makes the qualified byte the last one.

The request level is raised by a rising edge on the peripheral's request line. It is cleared only by the SYNC status. Dropping the request line never ends a transfer. All outputs are registered and change one clock after the inputs that cause them. Reset is synchronous and active high.

Top module: `lpc_dma_sync_term`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears the following after that edge: `req_active`, `err_flag`, `done_pulse`, `eot_pulse`, `pad_pulse`, the open-grant state and the request-edge history.
- R2: A rising edge of `periph_req` (low at the previous edge, high at this one) sets `req_active` after the edge. A falling edge of `periph_req` leaves `req_active` unchanged.
- R3: Within an open grant, a SYNC of 4'b0000 or 4'b1010 on the last byte of the grant does three things after the edge: `done_pulse` goes high for one cycle, `req_active` goes low, and `eot_pulse` stays low. The grant then closes.
- R4: Within an open two-byte grant, a SYNC of 4'b0000 or 4'b1010 on the first byte does the following:
  - `eot_pulse` and `done_pulse` go high for one cycle;
  - `req_active` goes low;
  - the grant closes, so the second byte is never taken.
- R5: `pad_pulse` accompanies `eot_pulse` only when the grant was latched as a write (`dir_write`=1). An early end on a read gives no `pad_pulse`.
- R6: A SYNC of 4'b1001 on a byte that is not the last of the grant advances to the next byte and produces no pulse. On the last byte, it pulses `done_pulse`, keeps `req_active` high and closes the grant.
- R7: If the grant was latched on a 16-bit channel (`chan_wide`=1), a SYNC of 4'b0000 or 4'b1010 on its first byte sets `err_flag`. The flag stays high until reset.
- R8: Within an open grant, any SYNC code other than 4'b0000, 4'b1010 and 4'b1001 has three effects: it sets `err_flag`, clears `req_active` and closes the grant without `done_pulse`.
- R9: A byte strobe has no effect in either of two cases: no grant is open, or `grant_start` is high in the same cycle. `grant_start` always opens a fresh grant at byte 0.
- R10: If a rising edge of `periph_req` falls in the same cycle as a byte that would clear the request (R3, R4, R8), `req_active` is high after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| grant_start | input | 1 | Opens a new grant and latches its attributes |
| grant_wide | input | 1 | Granted size: 1 = two bytes, 0 = one byte |
| dir_write | input | 1 | 1 = peripheral to host, 0 = host to peripheral |
| chan_wide | input | 1 | 1 = grant is on a 16-bit channel |
| periph_req | input | 1 | Peripheral DMA request line (rising edge sets request) |
| byte_stb | input | 1 | One data byte with its SYNC nibble is present |
| sync_code | input | 4 | Decoded SYNC nibble for the strobed byte |
| req_active | output | 1 | Request level to the DMA controller |
| done_pulse | output | 1 | One-cycle completion: controller steps address and count |
| eot_pulse | output | 1 | One-cycle early end of a two-byte grant |
| pad_pulse | output | 1 | One-cycle marker that the upper byte of a write is filler |
| err_flag | output | 1 | Sticky protocol error |

## Verification
Two functions can fall in the same cycle:

- **Request set and request clear.** A rising edge on the peripheral request line can arrive in the very cycle that a terminating or illegal SYNC clears the request. The directed part of the bench lines these two events up on purpose. The random part toggles the request line freely while bytes are strobed, so the collision also occurs at random. The outcome is judged against R10: the request must be high afterwards.
- **Grant start and byte strobe.** The second collision is a grant start arriving together with a byte strobe. Here the byte must be ignored and the counter must restart at byte 0.

// File: rtl/lpc_sync_pkg.sv
package lpc_sync_pkg;

  localparam int SYNC_W = 4;

  localparam logic [SYNC_W-1:0] SYNC_LAST_OK  = 4'b0000;
  localparam logic [SYNC_W-1:0] SYNC_LAST_ERR = 4'b1010;
  localparam logic [SYNC_W-1:0] SYNC_MORE     = 4'b1001;

  typedef enum logic [1:0] {
    CLS_TERM = 2'd0,
    CLS_MORE = 2'd1,
    CLS_BAD  = 2'd2
  } sync_cls_t;

  typedef struct packed {
    logic wide;
    logic wr;
    logic chan_wide;
  } grant_attr_t;

endpackage

// File: rtl/lpc_sync_classify.sv
module lpc_sync_classify
  import lpc_sync_pkg::*;
(
  input  logic [SYNC_W-1:0] code,
  output sync_cls_t         cls
);

  always_comb begin
    if (code == SYNC_LAST_OK || code == SYNC_LAST_ERR) begin
      cls = CLS_TERM;
    end else if (code == SYNC_MORE) begin
      cls = CLS_MORE;
    end else begin
      cls = CLS_BAD;
    end
  end

endmodule

// File: rtl/lpc_grant_tracker.sv
module lpc_grant_tracker
  import lpc_sync_pkg::*;
#(
  parameter int WIDE_BYTES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  grant_attr_t attr_in,
  input  logic        stb,
  input  sync_cls_t   cls,
  output logic        ev_term,
  output logic        ev_more_last,
  output logic        ev_bad,
  output logic        ev_early,
  output logic        ev_odd_err,
  output logic        attr_wr
);

  localparam int IDX_W = (WIDE_BYTES > 1) ? $clog2(WIDE_BYTES) : 1;
  localparam logic [IDX_W-1:0] IDX_WIDE_LAST = IDX_W'(WIDE_BYTES - 1);

  logic             busy_q;
  logic [IDX_W-1:0] idx_q;
  grant_attr_t      attr_q;
  logic             consume;
  logic             at_last;
  logic             at_first;

  assign consume  = busy_q && stb && !start;
  assign at_first = (idx_q == '0);
  assign at_last  = attr_q.wide ? (idx_q == IDX_WIDE_LAST) : at_first;

  assign ev_term      = consume && (cls == CLS_TERM);
  assign ev_bad       = consume && (cls == CLS_BAD);
  assign ev_more_last = consume && (cls == CLS_MORE) && at_last;
  assign ev_early     = ev_term && !at_last;
  assign ev_odd_err   = ev_term && attr_q.chan_wide && at_first;
  assign attr_wr      = attr_q.wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      attr_q <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      attr_q <= attr_in;
    end else if (ev_term || ev_bad || ev_more_last) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (consume && cls == CLS_MORE) begin
      idx_q <= idx_q + 1'b1;
    end
  end

endmodule

// File: rtl/lpc_req_keeper.sv
module lpc_req_keeper (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  input  logic drop,
  output logic req_q
);

  logic line_prev_q;
  logic rise;

  assign rise = line_in && !line_prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_prev_q <= 1'b0;
      req_q       <= 1'b0;
    end else begin
      line_prev_q <= line_in;
      if (rise) begin
        req_q <= 1'b1;
      end else if (drop) begin
        req_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/lpc_dma_sync_term.sv
module lpc_dma_sync_term
  import lpc_sync_pkg::*;
#(
  parameter int WIDE_BYTES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              grant_start,
  input  logic              grant_wide,
  input  logic              dir_write,
  input  logic              chan_wide,
  input  logic              periph_req,
  input  logic              byte_stb,
  input  logic [SYNC_W-1:0] sync_code,
  output logic              req_active,
  output logic              done_pulse,
  output logic              eot_pulse,
  output logic              pad_pulse,
  output logic              err_flag
);

  sync_cls_t   cls;
  grant_attr_t attr_in;
  logic        ev_term;
  logic        ev_more_last;
  logic        ev_bad;
  logic        ev_early;
  logic        ev_odd_err;
  logic        attr_wr;

  assign attr_in = '{wide: grant_wide, wr: dir_write, chan_wide: chan_wide};

  lpc_sync_classify u_cls (
    .code (sync_code),
    .cls  (cls)
  );

  lpc_grant_tracker #(.WIDE_BYTES(WIDE_BYTES)) u_trk (
    .clk          (clk),
    .rst          (rst),
    .start        (grant_start),
    .attr_in      (attr_in),
    .stb          (byte_stb),
    .cls          (cls),
    .ev_term      (ev_term),
    .ev_more_last (ev_more_last),
    .ev_bad       (ev_bad),
    .ev_early     (ev_early),
    .ev_odd_err   (ev_odd_err),
    .attr_wr      (attr_wr)
  );

  lpc_req_keeper u_req (
    .clk     (clk),
    .rst     (rst),
    .line_in (periph_req),
    .drop    (ev_term || ev_bad),
    .req_q   (req_active)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done_pulse <= 1'b0;
      eot_pulse  <= 1'b0;
      pad_pulse  <= 1'b0;
      err_flag   <= 1'b0;
    end else begin
      done_pulse <= ev_term || ev_more_last;
      eot_pulse  <= ev_early;
      pad_pulse  <= ev_early && attr_wr;
      if (ev_bad || ev_odd_err) begin
        err_flag <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/lpc_dma_sync_term_chk.sv
module lpc_dma_sync_term_chk (
  input logic clk,
  input logic rst,
  input logic byte_stb,
  input logic req_active,
  input logic done_pulse,
  input logic eot_pulse,
  input logic pad_pulse,
  input logic err_flag
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (!req_active && !err_flag && !done_pulse && !eot_pulse && !pad_pulse));

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(req_active) && !$past(byte_stb)) |-> req_active);

  // R4
  eot_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    eot_pulse |-> done_pulse);

  // R5
  pad_with_eot_chk: assert property (@(posedge clk) disable iff (rst)
    pad_pulse |-> eot_pulse);

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(err_flag)) |-> err_flag);

  // R8
  no_pulse_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(byte_stb)) |-> (!done_pulse && !eot_pulse));

endmodule

bind lpc_dma_sync_term lpc_dma_sync_term_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .byte_stb   (byte_stb),
  .req_active (req_active),
  .done_pulse (done_pulse),
  .eot_pulse  (eot_pulse),
  .pad_pulse  (pad_pulse),
  .err_flag   (err_flag)
);

// File: tb/lpc_dma_sync_term_test.sv
module lpc_dma_sync_term_test;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       grant_start, grant_wide, dir_write, chan_wide;
  logic       periph_req, byte_stb;
  logic [3:0] sync_code;
  logic       req_active, done_pulse, eot_pulse, pad_pulse, err_flag;

  int  n_vec  = 0;
  int  n_miss = 0;
  bit  finished = 1'b0;

  bit  m_req, m_err, m_busy, m_prev, m_wide, m_wr, m_chan;
  int  m_idx;
  bit  e_done, e_eot, e_pad;

  always #(CLK_PERIOD/2) clk = ~clk;

  lpc_dma_sync_term uut (
    .clk (clk), .rst (rst), .grant_start (grant_start), .grant_wide (grant_wide),
    .dir_write (dir_write), .chan_wide (chan_wide), .periph_req (periph_req),
    .byte_stb (byte_stb), .sync_code (sync_code), .req_active (req_active),
    .done_pulse (done_pulse), .eot_pulse (eot_pulse), .pad_pulse (pad_pulse),
    .err_flag (err_flag)
  );

  task automatic model_step();
    bit rise, cons, is_term, is_more, last, term, more, bad;
    if (rst) begin
      m_req = 0; m_err = 0; m_busy = 0; m_idx = 0; m_prev = 0;
      e_done = 0; e_eot = 0; e_pad = 0;
      return;
    end
    rise    = periph_req && !m_prev;
    m_prev  = periph_req;
    cons    = m_busy && byte_stb && !grant_start;
    is_term = (sync_code == 4'b0000) || (sync_code == 4'b1010);
    is_more = (sync_code == 4'b1001);
    last    = (m_idx == (m_wide ? 1 : 0));
    term    = cons && is_term;
    more    = cons && is_more;
    bad     = cons && !is_term && !is_more;
    e_done  = term || (more && last);
    e_eot   = term && !last;
    e_pad   = e_eot && m_wr;
    if (bad || (term && m_chan && m_idx == 0)) m_err = 1;
    if (rise) m_req = 1;
    else if (term || bad) m_req = 0;
    if (grant_start) begin
      m_busy = 1; m_idx = 0; m_wide = grant_wide; m_wr = dir_write; m_chan = chan_wide;
    end else if (term || bad || (more && last)) begin
      m_busy = 0; m_idx = 0;
    end else if (more) begin
      m_idx++;
    end
  endtask

  task automatic cmp(string tag, string fld, logic got, bit exp);
    n_vec++;
    if (got !== exp) begin
      n_miss++;
      $display("FAIL %s %s got %0b expected %0b at %0t", tag, fld, got, exp, $time);
    end
  endtask

  task automatic cyc(input bit r, gs, gw, dw, cw, pr, bs, input bit [3:0] code, input string tag);
    @(negedge clk);
    rst = r; grant_start = gs; grant_wide = gw; dir_write = dw; chan_wide = cw;
    periph_req = pr; byte_stb = bs; sync_code = code;
    model_step();
    @(posedge clk);
    #1;
    cmp(tag, "req_active", req_active, m_req);
    cmp(tag, "done_pulse", done_pulse, e_done);
    cmp(tag, "eot_pulse",  eot_pulse,  e_eot);
    cmp(tag, "pad_pulse",  pad_pulse,  e_pad);
    cmp(tag, "err_flag",   err_flag,   m_err);
  endtask

  task automatic idle(input bit pr, input string tag);
    cyc(0, 0, 0, 0, 0, pr, 0, 4'h0, tag);
  endtask

  function automatic bit [3:0] pick_code();
    int r = int'($urandom % 10);
    if (r < 4) return 4'b1001;
    if (r < 6) return 4'b0000;
    if (r < 8) return 4'b1010;
    return 4'($urandom % 16);
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_miss++;
      $display("FAIL watchdog expired got running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1 reset state
    cyc(1, 0, 0, 0, 0, 1, 1, 4'h0, "R1");
    cyc(1, 0, 0, 0, 0, 0, 0, 4'h0, "R1");
    // R2 rising edge sets, falling edge ignored
    idle(1, "R2");
    idle(0, "R2");
    idle(0, "R2");
    // R3 narrow read, terminate on last byte
    cyc(0, 1, 0, 0, 0, 0, 0, 4'h0, "R3");
    cyc(0, 0, 0, 0, 0, 0, 1, 4'b0000, "R3");
    idle(0, "R3");
    // R4 R5 wide read cut short: no pad, no error on 8-bit channel
    idle(1, "R4");
    cyc(0, 1, 1, 0, 0, 1, 0, 4'h0, "R4");
    cyc(0, 0, 0, 0, 0, 1, 1, 4'b1010, "R5");
    cyc(0, 0, 0, 0, 0, 0, 1, 4'b1001, "R9");
    // R6 more on both bytes of a wide grant keeps request
    idle(1, "R6");
    cyc(0, 1, 1, 0, 0, 1, 0, 4'h0, "R6");
    cyc(0, 0, 0, 0, 0, 1, 1, 4'b1001, "R6");
    cyc(0, 0, 0, 0, 0, 1, 1, 4'b1001, "R6");
    idle(0, "R6");
    // R9 start with simultaneous strobe ignores the byte
    cyc(0, 1, 0, 1, 0, 0, 1, 4'b0000, "R9");
    cyc(0, 0, 0, 0, 0, 0, 1, 4'b1001, "R9");
    // R4 R5 R7 wide write on 16-bit channel cut short
    cyc(0, 1, 1, 1, 1, 0, 0, 4'h0, "R7");
    cyc(0, 0, 0, 0, 0, 0, 1, 4'b0000, "R5");
    idle(0, "R7");
    // R8 illegal code after reset
    cyc(1, 0, 0, 0, 0, 0, 0, 4'h0, "R1");
    idle(1, "R8");
    cyc(0, 1, 0, 0, 0, 1, 0, 4'h0, "R8");
    cyc(0, 0, 0, 0, 0, 1, 1, 4'b0110, "R8");
    idle(1, "R8");
    // R10 rising edge together with a terminating byte
    cyc(1, 0, 0, 0, 0, 0, 0, 4'h0, "R1");
    cyc(0, 1, 0, 0, 0, 0, 0, 4'h0, "R10");
    cyc(0, 0, 0, 0, 0, 1, 1, 4'b0000, "R10");
    idle(1, "R10");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      bit gs = ($urandom % 6) == 0;
      bit pr = ($urandom % 8) == 0 ? !periph_req : periph_req;
      bit bs = ($urandom % 2) == 0;
      bit r  = (i == 2000);
      cyc(r, gs, 1'($urandom), 1'($urandom), 1'($urandom), pr, bs, pick_code(), "R6 R10 random");
    end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
    $finish;
  end

endmodule